// File: doc/BRIEF.md
# Paged DRAM Access Controller

This block connects a simple request port to a DRAM device whose address pins are shared between the row half and the column half of the address. A host request carries a flat address, a read/write flag and write data. The controller cuts the address into a row part and a column part. It opens the row by presenting the row part and pulling the row strobe low. It then presents the column part, sets the read/write line and pulls the column strobe low for one cycle. Read data comes back on the host side as a one-cycle pulse.

After an access the row stays open, so a later request to the same row costs only a new column strobe. A request to another row first closes the open row and then activates the new one. A refresh timer raises a refresh request at a fixed interval. The refresh waits for any access already in progress to finish, and it blocks new requests while it is pending. It closes an open row if needed and then runs a row-strobe-only cycle on the row named by an internal refresh counter. That counter steps through every row.

Top module: `dram_pager`

## Requirements
- R1: After a synchronous active-low reset the pins idle: both strobes high (1), read/write line 1 (read), address pins 0, write-data pins 0. The response strobe is 0 and req_ready is 1.
- R2: The host address splits as row = req_addr[PIN_W-1:0] and column = req_addr[2*PIN_W-1:PIN_W]. Pin n therefore carries address bit n in the row phase and bit n+PIN_W in the column phase.
- R3: A row activation drives the row on the pins for one cycle with the row strobe high, then holds the row for one cycle with the row strobe low.
- R4: A column access drives the column for one cycle with the row strobe low and the column strobe high, then holds it for exactly one cycle with the column strobe low. In both cycles the read/write line is 0 for a write and 1 for a read, and the write-data pins carry the write data for a write and 0 for a read. Outside these two cycles the read/write line is 1 and the write-data pins are 0. Between accesses with a row open, the row strobe stays low and the pins are 0.
- R5: A request to the row that is already open issues only the two column cycles. The row strobe stays low throughout.
- R6: A request to a different row first raises the row strobe for one cycle with pins 0, then performs the R3 activation and the R4 column access.
- R7: For a read, rsp_valid is 1 for exactly the one cycle after the column-strobe cycle. rsp_rdata then holds the device data present at the end of that strobe cycle.
- R8: req_ready is 1 only when no access is in progress (idle, or a row open and waiting) and no refresh is pending. A request is taken on a clock edge where req_valid and req_ready are both 1.
- R9: A refresh becomes pending every REF_PERIOD cycles after reset. If a row is open, the refresh first closes it with one cycle of row strobe high. It then drives the refresh row with the row strobe high for one cycle, holds it with the row strobe low for one cycle, and ends with one cycle of row strobe high and pins 0. The column strobe stays high throughout.
- R10: The refresh row starts at 0 after reset, rises by one after each refresh, and goes from 1023 back to 0.
- R11: A pending refresh starts at the next point where no access is in progress, before any further request is taken. An access already taken still completes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*PIN_W | Flat host address (column bits high, row bits low) |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DATA_W | Read data |
| dram_addr | output | PIN_W | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_rw | output | 1 | Read/write line, 1 = read, 0 = write |
| dram_din | output | DATA_W | Data to the device |
| dram_dout | input | DATA_W | Data from the device |

## Verification
Suppose the controller's record of which row is open is corrupted. Within two cycles of the next request, the pins show either a missing precharge-and-activate pair or an extra one, and the device model then returns data from the wrong cell on the following read. A wrong refresh row or timer count shows up on the address pins in the first refresh cycle after the fault, and every refresh after it stays shifted. A lost or duplicated response strobe is caught in the very cycle after the column strobe, because the pins and the host outputs are compared against the behavioural model on every clock.

// File: rtl/dram_pager_pkg.sv
// Shared types for the paged DRAM controller.
// Assumes: one sequencer state is active per clock; every state lasts one cycle
// except the two waiting states (idle and row open).
package dram_pager_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACT_SETUP,
        ST_ACT,
        ST_COL_SETUP,
        ST_STROBE,
        ST_OPEN,
        ST_PRECH,
        ST_REF_SETUP,
        ST_REF_ACT,
        ST_REF_PRE
    } seq_state_t;

endpackage

// File: rtl/dram_addr_split.sv
// Splits a flat host address into the row half (low bits) and the column
// half (high bits) that share the device's address pins.
// Assumes: host address width is exactly twice the pin count.
module dram_addr_split #(
    parameter int PIN_W = 10
) (
    input  logic [2*PIN_W-1:0] host_addr,
    output logic [PIN_W-1:0]   row_part,
    output logic [PIN_W-1:0]   col_part
);

    // row half on the low pins, column half above it
    assign row_part = host_addr[PIN_W-1:0];
    assign col_part = host_addr[2*PIN_W-1:PIN_W];

endmodule

// File: rtl/dram_refresh_ctr.sv
// Refresh interval timer and refresh row counter.
// Raises ref_pend every REF_PERIOD cycles. ref_done, a one-cycle pulse from the
// sequencer, clears it and advances the row. A timer tick on the same edge as
// ref_done leaves the request pending.
// Assumes: REF_PERIOD >= 2; the row count is 2**PIN_W.
module dram_refresh_ctr #(
    parameter int PIN_W      = 10,
    parameter int REF_PERIOD = 780
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_done,
    output logic             ref_pend,
    output logic [PIN_W-1:0] ref_row
);

    localparam int               CNT_W    = (REF_PERIOD > 1) ? $clog2(REF_PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REF_PERIOD - 1);
    localparam logic [PIN_W-1:0] ROW_LAST = {PIN_W{1'b1}};

    logic [CNT_W-1:0] tmr_q;
    logic             tick;

    assign tick = (tmr_q == CNT_LAST);

    // interval timer, wraps after REF_PERIOD cycles
    always_ff @(posedge clk) begin
        if (!rst_n)    tmr_q <= '0;
        else if (tick) tmr_q <= '0;
        else           tmr_q <= tmr_q + CNT_W'(1);
    end

    // pending flag: set by the timer, cleared when a refresh strobe finishes
    always_ff @(posedge clk) begin
        if (!rst_n)        ref_pend <= 1'b0;
        else if (tick)     ref_pend <= 1'b1;
        else if (ref_done) ref_pend <= 1'b0;
    end

    // refresh row counter, wraps from the last row to zero
    always_ff @(posedge clk) begin
        if (!rst_n)        ref_row <= '0;
        else if (ref_done) ref_row <= (ref_row == ROW_LAST) ? '0 : ref_row + PIN_W'(1);
    end

endmodule

// File: rtl/dram_seq.sv
// Access and refresh sequencer. A Moore machine: every pin value is decoded
// from the current state and the latched request, so each address is set up
// one full clock before its strobe falls. A row stays open after an access
// until a miss or a refresh closes it.
// Assumes: the device captures the row on the row-strobe fall and the column
// on the column-strobe fall, and read data is valid by the end of the strobe.
module dram_seq
    import dram_pager_pkg::*;
#(
    parameter int PIN_W  = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [PIN_W-1:0]  req_row,
    input  logic [PIN_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic              ref_pend,
    input  logic [PIN_W-1:0]  ref_row,
    output logic              ref_done,
    output logic [PIN_W-1:0]  pin_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              rw,
    output logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    seq_state_t        state, nxt;
    logic [PIN_W-1:0]  row_q, col_q;
    logic [DATA_W-1:0] wd_q;
    logic              we_q, miss_q;
    logic              accept, row_hit, col_phase, row_phase, ref_phase;

    assign req_ready = ((state == ST_IDLE) || (state == ST_OPEN)) && !ref_pend;
    assign accept    = req_valid && req_ready;
    assign row_hit   = (req_row == row_q);

    // next-state choice; refresh outranks a new request in both waiting states
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (ref_pend) nxt = ST_REF_SETUP;
                          else if (accept) nxt = ST_ACT_SETUP;
            ST_OPEN:      if (ref_pend) nxt = ST_PRECH;
                          else if (accept) nxt = row_hit ? ST_COL_SETUP : ST_PRECH;
            ST_PRECH:     nxt = miss_q ? ST_ACT_SETUP : ST_REF_SETUP;
            ST_ACT_SETUP: nxt = ST_ACT;
            ST_ACT:       nxt = ST_COL_SETUP;
            ST_COL_SETUP: nxt = ST_STROBE;
            ST_STROBE:    nxt = ST_OPEN;
            ST_REF_SETUP: nxt = ST_REF_ACT;
            ST_REF_ACT:   nxt = ST_REF_PRE;
            ST_REF_PRE:   nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // request latch, loaded on every accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
            we_q  <= 1'b0;
            wd_q  <= '0;
        end else if (accept) begin
            row_q <= req_row;
            col_q <= req_col;
            we_q  <= req_write;
            wd_q  <= req_wdata;
        end
    end

    // remembers whether a precharge belongs to a row miss or to a refresh
    always_ff @(posedge clk) begin
        if (!rst_n)                miss_q <= 1'b0;
        else if (state == ST_OPEN) miss_q <= accept && !row_hit;
    end

    // read response: one-cycle pulse after the read column strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (state == ST_STROBE) && !we_q;
            if ((state == ST_STROBE) && !we_q) rsp_rdata <= rd_data;
        end
    end

    // pin decode from state
    assign row_phase = (state == ST_ACT_SETUP) || (state == ST_ACT);
    assign col_phase = (state == ST_COL_SETUP) || (state == ST_STROBE);
    assign ref_phase = (state == ST_REF_SETUP) || (state == ST_REF_ACT);

    always_comb begin
        ras_n    = !((state == ST_ACT) || col_phase || (state == ST_OPEN) || (state == ST_REF_ACT));
        cas_n    = (state != ST_STROBE);
        rw       = col_phase ? !we_q : 1'b1;
        wr_data  = (col_phase && we_q) ? wd_q : '0;
        ref_done = (state == ST_REF_ACT);
        if (row_phase)      pin_addr = row_q;
        else if (col_phase) pin_addr = col_q;
        else if (ref_phase) pin_addr = ref_row;
        else                pin_addr = '0;
    end

endmodule

// File: rtl/dram_pager.sv
// Paged DRAM controller top: address split, sequencer and refresh counter.
// Assumes: the host holds a request stable until it is taken (valid/ready).
module dram_pager #(
    parameter int PIN_W      = 10,
    parameter int DATA_W     = 8,
    parameter int REF_PERIOD = 780
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [2*PIN_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [PIN_W-1:0]    dram_addr,
    output logic                dram_ras_n,
    output logic                dram_cas_n,
    output logic                dram_rw,
    output logic [DATA_W-1:0]   dram_din,
    input  logic [DATA_W-1:0]   dram_dout
);

    logic [PIN_W-1:0] row_part, col_part, ref_row;
    logic             ref_pend, ref_done;

    dram_addr_split #(.PIN_W(PIN_W)) u_split (
        .host_addr (req_addr),
        .row_part  (row_part),
        .col_part  (col_part)
    );

    dram_refresh_ctr #(.PIN_W(PIN_W), .REF_PERIOD(REF_PERIOD)) u_refresh (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_done (ref_done),
        .ref_pend (ref_pend),
        .ref_row  (ref_row)
    );

    dram_seq #(.PIN_W(PIN_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_row   (row_part),
        .req_col   (col_part),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .ref_pend  (ref_pend),
        .ref_row   (ref_row),
        .ref_done  (ref_done),
        .pin_addr  (dram_addr),
        .ras_n     (dram_ras_n),
        .cas_n     (dram_cas_n),
        .rw        (dram_rw),
        .wr_data   (dram_din),
        .rd_data   (dram_dout),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/dram_pager_chk.sv
// Protocol checker for the paged DRAM controller, bound to the top module.
// Assumes: synchronous active-low reset; observes ports only.
module dram_pager_chk #(
    parameter int PIN_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [PIN_W-1:0] dram_addr,
    input logic             dram_ras_n,
    input logic             dram_cas_n,
    input logic             dram_rw
);

    // column strobe only inside an open row
    assert_cas_inside_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    // column strobe lasts exactly one cycle
    assert_cas_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |=> dram_cas_n);

    // row address set up one cycle before the row strobe falls
    assert_row_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (dram_addr == $past(dram_addr)));

    // column address and direction set up one cycle before the column strobe falls
    assert_col_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> ((dram_addr == $past(dram_addr)) && (dram_rw == $past(dram_rw)) && !$past(dram_ras_n)));

    // response is a single-cycle pulse
    assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // response only after a read strobe
    assert_rsp_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!dram_cas_n && dram_rw));

    // a taken request is never followed at once by a strobe
    assert_accept_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> dram_cas_n);

endmodule

bind dram_pager dram_pager_chk #(.PIN_W(PIN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .dram_addr  (dram_addr),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_rw    (dram_rw)
);

// File: tb/sim_dram_pager.sv
// Bench: random host traffic, a behavioural device model and a slot-queue
// reference model compared against every output on every clock.
module sim_dram_pager;

    localparam int CLK_PERIOD = 10;
    localparam int PIN_W      = 10;
    localparam int DATA_W     = 8;
    localparam int REF_PERIOD = 40;
    localparam int RUN_CYCLES = 48000;
    localparam int ROWS       = 1 << PIN_W;

    localparam logic [3:0] K_PRE_MISS = 4'd0, K_ACT_SET = 4'd1, K_ACT = 4'd2,
                           K_COL_SET = 4'd3, K_STROBE = 4'd4, K_PRE_REF = 4'd5,
                           K_REF_SET = 4'd6, K_REF_ACT = 4'd7, K_REF_PRE = 4'd8,
                           K_IDLE = 4'd9, K_OPEN = 4'd10;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                req_valid, req_ready, req_write;
    logic [2*PIN_W-1:0]  req_addr;
    logic [DATA_W-1:0]   req_wdata;
    logic                rsp_valid;
    logic [DATA_W-1:0]   rsp_rdata;
    logic [PIN_W-1:0]    dram_addr;
    logic                dram_ras_n, dram_cas_n, dram_rw;
    logic [DATA_W-1:0]   dram_din, dram_dout;

    dram_pager #(.PIN_W(PIN_W), .DATA_W(DATA_W), .REF_PERIOD(REF_PERIOD)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_rw(dram_rw),
        .dram_din(dram_din), .dram_dout(dram_dout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [3:0]        kind;
        logic              ras_n;
        logic              cas_n;
        logic              rw;
        logic [PIN_W-1:0]  addr;
        logic [DATA_W-1:0] din;
        logic              rd;
        logic [DATA_W-1:0] rdata;
    } slot_t;

    slot_t             plan[$];
    logic [DATA_W-1:0] dev_mem [int];
    logic [DATA_W-1:0] shadow  [int];
    int  n_cmp = 0, n_bad = 0;
    bit  done = 0;

    // model state
    int  m_timer, m_refrow, m_open_row;
    bit  m_pend, m_open, m_rsp_v;
    logic [DATA_W-1:0] m_rsp_d;
    // device state
    int  dev_row;
    bit  dev_prev_ras;

    function automatic logic [7:0] seed_byte(int a);
        return 8'(a) ^ 8'(a >>> PIN_W) ^ 8'h5A;
    endfunction

    function automatic string kind_req(logic [3:0] k);
        case (k)
            K_PRE_MISS:            return "R6";
            K_ACT_SET, K_ACT:      return "R2,R3";
            K_COL_SET, K_STROBE:   return "R2,R4,R5";
            K_PRE_REF:             return "R11";
            K_REF_SET, K_REF_PRE:  return "R9";
            K_REF_ACT:             return "R10";
            K_IDLE:                return "R1";
            default:               return "R5";
        endcase
    endfunction

    function automatic slot_t mk(logic [3:0] k, logic ras, logic cas, logic rw_v,
                                 logic [PIN_W-1:0] a, logic [DATA_W-1:0] d,
                                 logic rd, logic [DATA_W-1:0] rdat);
        slot_t s;
        s.kind = k; s.ras_n = ras; s.cas_n = cas; s.rw = rw_v;
        s.addr = a; s.din = d; s.rd = rd; s.rdata = rdat;
        return s;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural device: row capture on strobe fall, column access on strobe low
    task automatic device_step();
        int key;
        if (!dram_ras_n && dev_prev_ras) dev_row = int'(dram_addr);
        dev_prev_ras = dram_ras_n;
        if (!dram_cas_n) begin
            key = int'(dram_addr) * ROWS + dev_row;
            if (!dram_rw) dev_mem[key] = dram_din;
            else dram_dout = dev_mem.exists(key) ? dev_mem[key] : seed_byte(key);
        end
    endtask

    task automatic push_access(int a, bit we, logic [DATA_W-1:0] wd);
        logic [PIN_W-1:0]  row, col;
        logic [DATA_W-1:0] rdat, dv;
        row  = PIN_W'(a);
        col  = PIN_W'(a >>> PIN_W);
        rdat = '0;
        if (!we) rdat = shadow.exists(a) ? shadow[a] : seed_byte(a);
        else shadow[a] = wd;
        dv = we ? wd : '0;
        if (m_open && int'(row) != m_open_row)
            plan.push_back(mk(K_PRE_MISS, 1, 1, 1, '0, '0, 0, '0));
        if (!m_open || int'(row) != m_open_row) begin
            plan.push_back(mk(K_ACT_SET, 1, 1, 1, row, '0, 0, '0));
            plan.push_back(mk(K_ACT, 0, 1, 1, row, '0, 0, '0));
        end
        plan.push_back(mk(K_COL_SET, 0, 1, !we, col, dv, 0, '0));
        plan.push_back(mk(K_STROBE, 0, 0, !we, col, dv, !we, rdat));
        m_open = 1;
        m_open_row = int'(row);
    endtask

    task automatic push_refresh();
        if (m_open) plan.push_back(mk(K_PRE_REF, 1, 1, 1, '0, '0, 0, '0));
        plan.push_back(mk(K_REF_SET, 1, 1, 1, PIN_W'(m_refrow), '0, 0, '0));
        plan.push_back(mk(K_REF_ACT, 0, 1, 1, PIN_W'(m_refrow), '0, 0, '0));
        plan.push_back(mk(K_REF_PRE, 1, 1, 1, '0, '0, 0, '0));
        m_open = 0;
    endtask

    initial begin
        bit last_acc;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; dram_dout = '0;
        dev_row = 0; dev_prev_ras = 1;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "ras_n", dram_ras_n, 1);
        chk("R1", "cas_n", dram_cas_n, 1);
        chk("R1", "rw", dram_rw, 1);
        chk("R1", "addr", dram_addr, 0);
        chk("R1", "din", dram_din, 0);
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "req_ready", req_ready, 1);
        rst_n = 1'b1;
        m_timer = 0; m_refrow = 0; m_open_row = 0;
        m_pend = 0; m_open = 0; m_rsp_v = 0; m_rsp_d = '0;
        last_acc = 0;
        for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
            slot_t cur;
            bit    exp_ready, acc, tick, old_pend, was_empty;
            int    dens, r, row, col;
            if (cyc != 0) @(negedge clk);
            device_step();
            was_empty = (plan.size() == 0);
            if (!was_empty) cur = plan[0];
            else if (m_open) cur = mk(K_OPEN, 0, 1, 1, '0, '0, 0, '0);
            else cur = mk(K_IDLE, 1, 1, 1, '0, '0, 0, '0);
            exp_ready = was_empty && !m_pend;
            // compare every output against the model
            chk(kind_req(cur.kind), "ras_n", dram_ras_n, cur.ras_n);
            chk(kind_req(cur.kind), "cas_n", dram_cas_n, cur.cas_n);
            chk(kind_req(cur.kind), "rw", dram_rw, cur.rw);
            chk(kind_req(cur.kind), "addr", dram_addr, cur.addr);
            chk(kind_req(cur.kind), "din", dram_din, cur.din);
            chk("R8,R11", "req_ready", req_ready, exp_ready);
            chk("R7", "rsp_valid", rsp_valid, m_rsp_v);
            if (m_rsp_v) chk("R7", "rsp_rdata", rsp_rdata, m_rsp_d);
            // stimulus: hold a request until taken, then maybe issue another
            if (last_acc) req_valid = 1'b0;
            dens = (cyc < 6000 || cyc > 44000) ? 2 : 40;
            if (!req_valid && ($urandom % dens) == 0) begin
                r   = $urandom % 5;
                row = (r < 2) ? 3 : (r == 2) ? 512 : (r == 3) ? 1023 : int'($urandom % ROWS);
                col = ($urandom % 2) ? int'($urandom % 4) : int'($urandom % ROWS);
                req_valid = 1'b1;
                req_write = 1'($urandom % 2);
                req_addr  = (2*PIN_W)'(col * ROWS + row);
                req_wdata = DATA_W'($urandom);
            end
            acc = req_valid && exp_ready;
            last_acc = acc;
            // model advance to the next cycle
            m_rsp_v = (cur.kind == K_STROBE) && cur.rd;
            if (m_rsp_v) m_rsp_d = cur.rdata;
            if (cur.kind == K_REF_ACT) m_refrow = (m_refrow + 1) % ROWS;
            tick = (m_timer == REF_PERIOD - 1);
            m_timer = tick ? 0 : m_timer + 1;
            old_pend = m_pend;
            if (tick) m_pend = 1;
            else if (cur.kind == K_REF_ACT) m_pend = 0;
            if (!was_empty) plan.delete(0);
            else if (old_pend) push_refresh();
            else if (acc) push_access(int'(req_addr), req_write, req_wdata);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule